// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block sits between one client and the memory system. It turns the client's virtual addresses into physical addresses by reading a single-level table kept in memory. Each table word holds a physical page number. Pages are 4 KiB, so the low 12 address bits pass through unchanged and the page number is the address shifted right by 12. A programmable window of virtual pages selects which part of the table is valid. The window is set by a first virtual page and a page count. An access outside the window is not aborted. It is sent to a fault page and flagged. A four-entry translation cache keeps recent results, and software must flush it after editing the table.

The configuration port is a simple 32-bit register slave. Writes are strobed. Read data depends combinationally on the address. Two register layouts are available through a parameter. Layout 1, the default, has a version word and separate read and write fault pages. Layout 0 is more compact and has one fault page. A client request is accepted when `req_valid` and `req_ready` are both high. Its result appears on the `rsp_*` pins exactly once. A cache miss sends one word read out on the memory port. The block then waits for `mem_rvalid`.

Top module: `pgtab_xlat`

## Requirements
- R1: After reset `rsp_valid`, `rsp_fault` and `mem_req` are low, `req_ready` is low, and every register reads zero except the version word.
- R2: While control bit 0 (enable) and bit 4 (bypass) are both 0, `req_ready` stays low. A held `req_valid` then produces no response and no table read.
- R3: When control bit 4 is 1, an accepted request returns `rsp_paddr` equal to the virtual address, with no fault. The result comes in the cycle after acceptance and no table read is made. Bypass takes priority over enable.
- R4: On a cache miss inside the window, one table read is issued in the cycle after acceptance. It goes to address (table page << 12) + (vpn − first vpn) × 4. The response comes one cycle after `mem_rvalid`, with entry bits [19:0] << 12 plus the low 12 bits of the virtual address.
- R5: A request whose page is cached is answered in the cycle after acceptance without a table read.
- R6: A page below the first vpn, or more than range pages above it, gives `rsp_fault`=1 and the fault page << 12 plus the low 12 bits. This happens in the next cycle, with no table read. Reads use the read fault page and writes (`req_write`=1) use the write fault page. Page first+range is still inside the window.
- R7: A table word of zero yields a fault with the direction's fault page and is not cached, so a repeat access reads the table again.
- R8: Writing 0xFFFFFFFF to the update register empties the cache. Writing any other value leaves cached results in use.
- R9: If the cache is flushed while a miss is outstanding, the miss still returns its result, but that result is not cached.
- R10: The cache holds four translations and replaces them in round-robin fill order.
- R11: In layout 1 the offsets are: 0x00 version (bits 15:8 = 1), 0x04 control, 0x08 update (reads 0), 0x0C authorization word, 0x10 table page, 0x14 read fault page, 0x18 write fault page, 0x1C first vpn, 0x20 range. Control reads back bits 0, 1 and 4 as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | AW | Virtual address |
| req_write | input | 1 | Request direction, 1 = write |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | AW | Translated physical address |
| rsp_fault | output | 1 | Result uses a fault page |
| mem_req | output | 1 | Table word read request (one cycle) |
| mem_addr | output | AW | Byte address of table word |
| mem_rvalid | input | 1 | Table word returned |
| mem_rdata | input | 32 | Table word |

## Verification
A cache flush and the completion of an outstanding miss can occur together. The fill may be due in the very cycle of the update write, or the flush may land while the table read is still pending. The bench stretches the memory reply latency and writes the update register partway through the wait. It first checks that the pending request still receives its correct address. It then checks that a repeat access to the same page has to read the table again, which shows the late result was not cached. The bench's reference model tracks the cache contents and the round-robin slot for every access, so any wrong fill or eviction shows up as an extra or missing table read.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   localparam int unsigned PGX_PG_SHIFT = 12;
   localparam int unsigned PGX_EW       = 32;

   typedef enum logic {
      PGX_IDLE = 1'b0,
      PGX_WAIT = 1'b1
   } pgx_state_e;
endpackage

// File: rtl/pgx_regs.sv
module pgx_regs #(
   parameter int unsigned VARIANT = 1,
   parameter int unsigned RAW     = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned PNW     = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [RAW-1:0] reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic           cfg_en,
   output logic           cfg_byp,
   output logic [PNW-1:0] first_vpn,
   output logic [PNW-1:0] vpn_range,
   output logic [PNW-1:0] first_ppn,
   output logic [PNW-1:0] dflt_rd,
   output logic [PNW-1:0] dflt_wr,
   output logic           flush
);
   localparam bit HAS_VER = (VARIANT == 1);
   localparam logic [RAW-1:0] OFS_VER   = RAW'(8'h00);
   localparam logic [RAW-1:0] OFS_CFG   = RAW'(HAS_VER ? 8'h04 : 8'h00);
   localparam logic [RAW-1:0] OFS_UPD   = RAW'(HAS_VER ? 8'h08 : 8'h04);
   localparam logic [RAW-1:0] OFS_AUTH  = RAW'(8'h0C);
   localparam logic [RAW-1:0] OFS_FPPN  = RAW'(8'h10);
   localparam logic [RAW-1:0] OFS_DRD   = RAW'(8'h14);
   localparam logic [RAW-1:0] OFS_DWR   = RAW'(HAS_VER ? 8'h18 : 8'h14);
   localparam logic [RAW-1:0] OFS_FVPN  = RAW'(HAS_VER ? 8'h1C : 8'h08);
   localparam logic [RAW-1:0] OFS_RANGE = RAW'(HAS_VER ? 8'h20 : 8'h0C);
   localparam logic [DW-1:0]  VER_WORD  = DW'(VARIANT) << 8;

   generate
      if (VARIANT > 1) begin : g_bad_variant
         $error("pgx_regs: VARIANT must be 0 or 1");
      end
      if (RAW < 6) begin : g_bad_raw
         $error("pgx_regs: RAW too narrow for the register map");
      end
      if (DW != 32) begin : g_bad_dw
         $error("pgx_regs: register width must be 32");
      end
      if (PNW > DW) begin : g_bad_pnw
         $error("pgx_regs: page number wider than a register");
      end
   endgenerate

   logic gate_q;
   logic [DW-1:0] auth_q;

   assign flush = reg_wr && (reg_addr == OFS_UPD) && (reg_wdata == {DW{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en    <= 1'b0;
         gate_q    <= 1'b0;
         cfg_byp   <= 1'b0;
         first_vpn <= '0;
         vpn_range <= '0;
         first_ppn <= '0;
         dflt_rd   <= '0;
         dflt_wr   <= '0;
      end else if (reg_wr) begin
         if (reg_addr == OFS_CFG) begin
            cfg_en  <= reg_wdata[0];
            gate_q  <= reg_wdata[1];
            cfg_byp <= reg_wdata[4];
         end
         if (reg_addr == OFS_FVPN)  first_vpn <= reg_wdata[PNW-1:0];
         if (reg_addr == OFS_RANGE) vpn_range <= reg_wdata[PNW-1:0];
         if (reg_addr == OFS_FPPN)  first_ppn <= reg_wdata[PNW-1:0];
         if (reg_addr == OFS_DRD)   dflt_rd   <= reg_wdata[PNW-1:0];
         if (reg_addr == OFS_DWR)   dflt_wr   <= reg_wdata[PNW-1:0];
      end
   end

   generate
      if (HAS_VER) begin : g_auth
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               auth_q <= '0;
            else if (reg_wr && reg_addr == OFS_AUTH)
               auth_q <= reg_wdata;
         end
      end else begin : g_no_auth
         assign auth_q = '0;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (HAS_VER && reg_addr == OFS_VER)
         reg_rdata = VER_WORD;
      else if (reg_addr == OFS_CFG)
         reg_rdata = DW'({cfg_byp, 2'b00, gate_q, cfg_en});
      else if (HAS_VER && reg_addr == OFS_AUTH)
         reg_rdata = auth_q;
      else if (reg_addr == OFS_FPPN)
         reg_rdata = DW'(first_ppn);
      else if (reg_addr == OFS_DRD)
         reg_rdata = DW'(dflt_rd);
      else if (reg_addr == OFS_DWR)
         reg_rdata = DW'(dflt_wr);
      else if (reg_addr == OFS_FVPN)
         reg_rdata = DW'(first_vpn);
      else if (reg_addr == OFS_RANGE)
         reg_rdata = DW'(vpn_range);
   end
endmodule

// File: rtl/pgx_window.sv
module pgx_window #(
   parameter int unsigned AW  = 32,
   parameter int unsigned PNW = 20
) (
   input  logic [PNW-1:0] vpn,
   input  logic [PNW-1:0] first_vpn,
   input  logic [PNW-1:0] vpn_range,
   input  logic [PNW-1:0] first_ppn,
   output logic           in_win,
   output logic [AW-1:0]  ent_addr
);
   localparam int unsigned OFW = AW - PNW;

   generate
      if (PNW + 2 > AW) begin : g_bad_width
         $error("pgx_window: address too narrow for table indexing");
      end
   endgenerate

   logic [PNW-1:0] delta;

   assign delta    = vpn - first_vpn;
   assign in_win   = (vpn >= first_vpn) && (delta <= vpn_range);
   assign ent_addr = {first_ppn, {OFW{1'b0}}} + AW'({delta, 2'b00});
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned PNW   = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [PNW-1:0] lk_vpn,
   output logic           lk_hit,
   output logic [PNW-1:0] lk_ppn,
   input  logic           fill,
   input  logic [PNW-1:0] fill_vpn,
   input  logic [PNW-1:0] fill_ppn,
   input  logic           flush
);
   localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pgx_tlb: DEPTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] match;
   logic [PNW-1:0]   ppn_arr [DEPTH];
   logic [PTRW-1:0]  ptr;

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_ent
         logic           vld;
         logic [PNW-1:0] tag;
         logic [PNW-1:0] ppn;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld <= 1'b0;
               tag <= '0;
               ppn <= '0;
            end else if (flush) begin
               vld <= 1'b0;
            end else if (fill && ptr == PTRW'(g)) begin
               vld <= 1'b1;
               tag <= fill_vpn;
               ppn <= fill_ppn;
            end
         end

         assign match[g]   = vld && (tag == lk_vpn);
         assign ppn_arr[g] = ppn;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (fill && !flush)
         ptr <= (ptr == PTRW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   end

   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < DEPTH; i++)
         if (match[i]) lk_ppn = lk_ppn | ppn_arr[i];
   end

   assign lk_hit = |match;
endmodule

// File: rtl/pgtab_xlat.sv
module pgtab_xlat import pgx_pkg::*; #(
   parameter int unsigned VARIANT   = 1,
   parameter int unsigned AW        = 32,
   parameter int unsigned TLB_DEPTH = 4,
   parameter int unsigned RAW       = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [RAW-1:0] reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic [31:0]    reg_rdata,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [AW-1:0]  req_vaddr,
   input  logic           req_write,
   output logic           rsp_valid,
   output logic [AW-1:0]  rsp_paddr,
   output logic           rsp_fault,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rvalid,
   input  logic [31:0]    mem_rdata
);
   localparam int unsigned OFW = PGX_PG_SHIFT;
   localparam int unsigned PNW = AW - OFW;

   generate
      if (AW <= OFW || PNW > PGX_EW) begin : g_bad_aw
         $error("pgtab_xlat: AW out of range");
      end
   endgenerate

   logic           cfg_en, cfg_byp, flush;
   logic [PNW-1:0] first_vpn, vpn_range, first_ppn, dflt_rd, dflt_wr;
   logic [PNW-1:0] req_vpn, req_dflt, pend_dflt, tlb_ppn, ent_ppn;
   logic [OFW-1:0] req_off;
   logic           in_win, tlb_hit, fill, acc, ent_zero;
   logic [AW-1:0]  ent_addr;

   pgx_state_e     st;
   logic [PNW-1:0] pend_vpn;
   logic [OFW-1:0] pend_off;
   logic           pend_wr, pend_stale;

   pgx_regs #(.VARIANT(VARIANT), .RAW(RAW), .DW(32), .PNW(PNW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_en(cfg_en),
      .cfg_byp(cfg_byp), .first_vpn(first_vpn), .vpn_range(vpn_range),
      .first_ppn(first_ppn), .dflt_rd(dflt_rd), .dflt_wr(dflt_wr), .flush(flush)
   );

   assign req_vpn = req_vaddr[AW-1:OFW];
   assign req_off = req_vaddr[OFW-1:0];

   pgx_window #(.AW(AW), .PNW(PNW)) u_win (
      .vpn(req_vpn), .first_vpn(first_vpn), .vpn_range(vpn_range),
      .first_ppn(first_ppn), .in_win(in_win), .ent_addr(ent_addr)
   );

   assign ent_ppn  = mem_rdata[PNW-1:0];
   assign ent_zero = (mem_rdata == '0);
   assign fill     = (st == PGX_WAIT) && mem_rvalid && !ent_zero && !pend_stale && !flush;

   pgx_tlb #(.DEPTH(TLB_DEPTH), .PNW(PNW)) u_tlb (
      .clk(clk), .rst_n(rst_n), .lk_vpn(req_vpn), .lk_hit(tlb_hit),
      .lk_ppn(tlb_ppn), .fill(fill), .fill_vpn(pend_vpn),
      .fill_ppn(ent_ppn), .flush(flush)
   );

   assign req_ready = (st == PGX_IDLE) && (cfg_en || cfg_byp);
   assign acc       = req_valid && req_ready;
   assign req_dflt  = req_write ? dflt_wr : dflt_rd;
   assign pend_dflt = pend_wr ? dflt_wr : dflt_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PGX_IDLE;
         rsp_valid  <= 1'b0;
         rsp_paddr  <= '0;
         rsp_fault  <= 1'b0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
         pend_vpn   <= '0;
         pend_off   <= '0;
         pend_wr    <= 1'b0;
         pend_stale <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         mem_req   <= 1'b0;
         if (acc) begin
            if (cfg_byp) begin
               rsp_valid <= 1'b1;
               rsp_fault <= 1'b0;
               rsp_paddr <= req_vaddr;
            end else if (!in_win) begin
               rsp_valid <= 1'b1;
               rsp_fault <= 1'b1;
               rsp_paddr <= {req_dflt, req_off};
            end else if (tlb_hit) begin
               rsp_valid <= 1'b1;
               rsp_fault <= 1'b0;
               rsp_paddr <= {tlb_ppn, req_off};
            end else begin
               st         <= PGX_WAIT;
               mem_req    <= 1'b1;
               mem_addr   <= ent_addr;
               pend_vpn   <= req_vpn;
               pend_off   <= req_off;
               pend_wr    <= req_write;
               pend_stale <= flush;
            end
         end
         if (st == PGX_WAIT) begin
            if (flush) pend_stale <= 1'b1;
            if (mem_rvalid) begin
               st        <= PGX_IDLE;
               rsp_valid <= 1'b1;
               rsp_fault <= ent_zero;
               rsp_paddr <= ent_zero ? {pend_dflt, pend_off} : {ent_ppn, pend_off};
            end
         end
      end
   end
endmodule

// File: rtl/pgx_check.sv
module pgx_check #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_vaddr,
   input logic          rsp_valid,
   input logic [AW-1:0] rsp_paddr,
   input logic          rsp_fault,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rvalid,
   input logic          cfg_en,
   input logic          cfg_byp
);
   a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !cfg_byp) |-> !req_ready);

   a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && cfg_byp) |=>
         (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));

   a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   a_r4_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   a_r1_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rvalid)));
endmodule

bind pgtab_xlat pgx_check #(.AW(AW)) u_pgx_check (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
   .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_rvalid(mem_rvalid), .cfg_en(cfg_en), .cfg_byp(cfg_byp)
);

// File: tb/pgtab_xlat_test.sv
`timescale 1ns/1ps
module pgtab_xlat_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        req_valid, req_ready, req_write;
   logic [31:0] req_vaddr;
   logic        rsp_valid, rsp_fault;
   logic [31:0] rsp_paddr;
   logic        mem_req, mem_rvalid;
   logic [31:0] mem_addr, mem_rdata;

   always #5 clk = ~clk;

   pgtab_xlat uut (.*);

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic ck(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory model
   logic [31:0] tbl [logic [31:0]];
   int          mem_lat = 2;
   int          n_rd = 0;
   logic [31:0] last_rd;

   function automatic logic [31:0] tbl_word(input logic [31:0] a);
      return tbl.exists(a) ? tbl[a] : 32'h0;
   endfunction

   initial begin
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      forever begin
         @(negedge clk);
         if (mem_req) begin
            n_rd++;
            last_rd = mem_addr;
            repeat (mem_lat) @(negedge clk);
            mem_rdata  = tbl_word(last_rd);
            mem_rvalid = 1'b1;
            @(negedge clk);
            mem_rvalid = 1'b0;
         end
      end
   end

   // reference model state
   bit          m_byp = 0;
   bit          m_nofill = 0;
   logic [19:0] m_fvpn = 0, m_range = 0, m_fppn = 0, m_drd = 0, m_dwr = 0;
   logic [19:0] mt [4];
   logic [19:0] mp [4];
   bit          mv [4];
   int          mptr = 0;

   function automatic void m_flush();
      for (int i = 0; i < 4; i++) mv[i] = 0;
   endfunction

   task automatic wreg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic cfgw(input logic [31:0] d);
      wreg(8'h04, d);
      m_byp = d[4];
   endtask

   task automatic upd(input logic [31:0] d);
      wreg(8'h08, d);
      if (d == 32'hFFFF_FFFF) m_flush();
   endtask

   task automatic xl(input logic [31:0] va, input bit wr, input string req);
      logic [19:0] vpn, d, dflt;
      logic [11:0] off;
      logic [31:0] ex, ea, ent;
      bit ef, em;
      int hi, rd0, cyc;
      vpn = va[31:12]; off = va[11:0]; d = vpn - m_fvpn;
      dflt = wr ? m_dwr : m_drd;
      ef = 0; em = 0; ea = '0; hi = -1;
      if (m_byp) begin
         ex = va;
      end else if (vpn < m_fvpn || d > m_range) begin
         ex = {dflt, off}; ef = 1;
      end else begin
         for (int i = 0; i < 4; i++) if (mv[i] && mt[i] == vpn) hi = i;
         if (hi >= 0) begin
            ex = {mp[hi], off};
         end else begin
            em  = 1;
            ea  = {m_fppn, 12'h000} + {10'b0, d, 2'b00};
            ent = tbl_word(ea);
            if (ent == 0) begin
               ex = {dflt, off}; ef = 1;
            end else begin
               ex = {ent[19:0], off};
               if (!m_nofill) begin
                  mt[mptr] = vpn; mp[mptr] = ent[19:0]; mv[mptr] = 1;
                  mptr = (mptr + 1) % 4;
               end
            end
         end
      end
      @(negedge clk);
      ck(req, "req_ready", {31'b0, req_ready}, 32'd1);
      req_valid = 1'b1; req_vaddr = va; req_write = wr;
      rd0 = n_rd;
      @(posedge clk);
      #1 req_valid = 1'b0;
      cyc = 0;
      while (!rsp_valid && cyc < 40) begin
         @(posedge clk);
         #1 cyc++;
      end
      ck(req, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
      ck(req, "rsp_paddr", rsp_paddr, ex);
      ck(req, "rsp_fault", {31'b0, rsp_fault}, {31'b0, ef});
      @(negedge clk);
      #2;
      ck(req, "table reads", n_rd - rd0, {31'b0, em});
      if (em) ck(req, "table address", last_rd, ea);
      else    ck(req, "latency", cyc, 0);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      int rd0;
      reg_wr = 0; reg_addr = 0; reg_wdata = 0;
      req_valid = 0; req_vaddr = 0; req_write = 0;
      m_flush();
      repeat (3) @(posedge clk);
      #1;
      ck("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 0);
      ck("R1", "mem_req in reset", {31'b0, mem_req}, 0);
      ck("R1", "rsp_fault in reset", {31'b0, rsp_fault}, 0);
      @(negedge clk) rst_n = 1'b1;
      rreg(8'h04, rv); ck("R1", "control after reset", rv, 0);
      rreg(8'h10, rv); ck("R1", "table page after reset", rv, 0);
      ck("R2", "ready after reset", {31'b0, req_ready}, 0);
      rreg(8'h00, rv); ck("R11", "version word", rv, 32'h0000_0100);
      rreg(8'h08, rv); ck("R11", "update reads zero", rv, 0);

      wreg(8'h10, 32'h80); m_fppn = 20'h80;
      wreg(8'h1C, 32'h10); m_fvpn = 20'h10;
      wreg(8'h20, 32'h7);  m_range = 20'h7;
      wreg(8'h14, 32'h3A); m_drd = 20'h3A;
      wreg(8'h18, 32'h3B); m_dwr = 20'h3B;
      wreg(8'h0C, 32'h5A);
      rreg(8'h1C, rv); ck("R11", "first vpn", rv, 32'h10);
      rreg(8'h20, rv); ck("R11", "range", rv, 32'h7);
      rreg(8'h18, rv); ck("R11", "write fault page", rv, 32'h3B);
      rreg(8'h14, rv); ck("R11", "read fault page", rv, 32'h3A);
      rreg(8'h0C, rv); ck("R11", "authorization word", rv, 32'h5A);
      for (int i = 0; i < 8; i++)
         tbl[32'h80000 + i * 4] = (i == 3) ? 32'h0 : 32'h500 + i;

      // R2: stalled with enable and bypass clear
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h10000; req_write = 1'b0;
      rd0 = n_rd;
      repeat (3) begin
         @(posedge clk);
         #1 ck("R2", "no response while stalled", {31'b0, rsp_valid}, 0);
         ck("R2", "ready while stalled", {31'b0, req_ready}, 0);
      end
      @(negedge clk) req_valid = 1'b0;
      #2 ck("R2", "no table read while stalled", n_rd - rd0, 0);

      cfgw(32'h10);
      xl(32'h1234_5678, 0, "R3");
      cfgw(32'h13);
      rreg(8'h04, rv); ck("R11", "control readback", rv, 32'h13);
      xl(32'hDEAD_BEEF, 1, "R3");

      cfgw(32'h03);
      xl(32'h0001_0ABC, 0, "R4");
      xl(32'h0001_0DEF, 1, "R5");
      xl(32'h0001_1004, 0, "R4");
      xl(32'h0001_1FFC, 0, "R5");

      xl(32'h0000_F123, 0, "R6");
      xl(32'h0000_F123, 1, "R6");
      xl(32'h0001_7FFF, 0, "R6");
      xl(32'h0001_8000, 1, "R6");
      xl(32'h0001_8000, 0, "R6");

      xl(32'h0001_3010, 0, "R7");
      xl(32'h0001_3020, 1, "R7");

      upd(32'h1);
      xl(32'h0001_0000, 0, "R8");
      tbl[32'h80000] = 32'h600;
      xl(32'h0001_0004, 0, "R8");
      upd(32'hFFFF_FFFF);
      xl(32'h0001_0008, 0, "R8");

      upd(32'hFFFF_FFFF);
      xl(32'h0001_0000, 0, "R10");
      xl(32'h0001_1000, 0, "R10");
      xl(32'h0001_2000, 0, "R10");
      xl(32'h0001_4000, 0, "R10");
      xl(32'h0001_5000, 0, "R10");
      xl(32'h0001_1000, 0, "R10");
      xl(32'h0001_0000, 0, "R10");
      xl(32'h0001_2000, 0, "R10");

      mem_lat = 6;
      m_nofill = 1;
      fork
         xl(32'h0001_6123, 0, "R9");
         begin
            repeat (3) @(negedge clk);
            upd(32'hFFFF_FFFF);
         end
      join
      m_nofill = 0;
      mem_lat = 2;
      xl(32'h0001_6456, 0, "R9");
      xl(32'h0001_6789, 0, "R9");

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule